// File: doc/BRIEF.md
# Banked Interrupt Controller with Summary Word

This block gathers 72 level-sensitive interrupt lines into three banks: two 32-line peripheral banks (global numbers 0–31 and 32–63) and an 8-line local bank (global numbers 64–71). Each line's global number is its bank index times 32 plus its bit within the bank. Every bank keeps a sampled raw view of its lines, a per-line enable mask, and a masked view that is the raw view ANDed with the enable mask. Enables are changed only through separate set-ones and clear-ones registers, so software never needs a read-modify-write.

A summary word lets an interrupt handler find the source in one read. It combines the local masked lines, one "anything pending" flag per peripheral bank, and eleven shortcut bits that mirror frequently used peripheral lines. A fast-interrupt selector routes one chosen line to a separate `fiq_o` output and removes that line from the normal `irq_o` output.

Software reaches the block through a single-cycle word register port. The port has one request per cycle and gives registered read data.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, the fast-interrupt selector is disabled, `irq_o` and `fiq_o` are 0 and `rdata_o` is 0.
- R2: A write to an enable-set register (word 4 = bank 0, 5 = bank 1, 6 = local, low 8 bits) sets each enable bit whose write bit is 1. Enable bits whose write bit is 0 keep their value. A read of words 4–6 returns the current enable mask.
- R3: A write to an enable-clear register (word 7 = bank 0, 8 = bank 1, 9 = local) clears each enable bit whose write bit is 1. Enable bits whose write bit is 0 keep their value. A read of words 7–9 returns the current enable mask of that bank.
- R4: Each line is sampled on every clock edge. Words 10, 11 and 12 return the sampled lines of bank 0, bank 1 and local, whatever the enables are. Words 1 and 2 return the sampled lines ANDed with the enables of bank 0 and bank 1.
- R5: Summary word 0 bits 7:0 hold the masked state of local lines 64–71, with bit k holding line 64+k.
- R6: Summary bit 8 is 1 when any masked bank-0 line is set. Summary bit 9 is 1 when any masked bank-1 line is set.
- R7: Summary bits 10 to 20 hold, in this order, the masked state of global lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62. Summary bits 31:21 read 0.
- R8: Word 3 is the fast-interrupt control register: bits 6:0 select a global line and bit 7 enables routing. It reads back as written, with bits 31:8 reading 0. `fiq_o` is 1 exactly when bit 7 is 1, the selected number is below 72, and that line's sampled value is 1. The line's enable bit plays no part. Writing 0 turns routing off.
- R9: `irq_o` is 1 exactly when some masked line is set, not counting the line selected for routing while routing is enabled.
- R10: A read request gives its data on `rdata_o` after the next clock edge, taken from the state before that edge. `rdata_o` holds its value in cycles without a read. Words 13–15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 72 | Interrupt lines; bit n is global line n |
| req_i | input | 1 | Register access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can happen in the same cycle: an enable set or clear write lands on the same edge at which a line's sampled value changes. A read can also hit a register that another edge is about to change. The bench provokes both with directed steps and with a long mixed stretch. In that stretch, random writes to every register go together with random line changes. A behavioural reference model is advanced on each clock edge and compared with `irq_o`, `fiq_o` and `rdata_o` in every cycle, so any ordering slip between the sampling and the register update shows up as a mismatch.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int BANK_W  = 32;
    localparam int LOC_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int NUM_SC  = 11;

    // Global line numbers mirrored by the shortcut bits, lowest bit first.
    localparam int unsigned SC_MAP [NUM_SC] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    typedef enum logic [ADDR_W-1:0] {
        A_SUMMARY = 4'd0,
        A_MPEND0  = 4'd1,
        A_MPEND1  = 4'd2,
        A_FIQCTL  = 4'd3,
        A_SET0    = 4'd4,
        A_SET1    = 4'd5,
        A_SETL    = 4'd6,
        A_CLR0    = 4'd7,
        A_CLR1    = 4'd8,
        A_CLRL    = 4'd9,
        A_RAW0    = 4'd10,
        A_RAW1    = 4'd11,
        A_RAWL    = 4'd12
    } reg_addr_e;

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] masked_o
);

    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] en;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.raw = src_i;
        if (set_we) begin
            s_d.en = s_q.en | wdata_i;
        end else if (clr_we) begin
            s_d.en = s_q.en & ~wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_o    = s_q.raw;
    assign en_o     = s_q.en;
    assign masked_o = s_q.raw & s_q.en;

    p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

    p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));

    p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en_o & $past(wdata_i)) == '0));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_o));

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_ctrl_pkg::*;
#(
    parameter int BW = BANK_W,
    parameter int LW = LOC_W
) (
    input  logic [BW-1:0]     m0_i,
    input  logic [BW-1:0]     m1_i,
    input  logic [LW-1:0]     ml_i,
    output logic [DATA_W-1:0] sum_o
);

    localparam int SC_BASE = LW + 2;

    logic [2*BW-1:0]     periph;
    logic [NUM_SC-1:0]   sc_bits;

    assign periph = {m1_i, m0_i};

    for (genvar gi = 0; gi < NUM_SC; gi++) begin : g_sc
        assign sc_bits[gi] = periph[SC_MAP[gi]];
    end

    always_comb begin
        sum_o                            = '0;
        sum_o[LW-1:0]                    = ml_i;
        sum_o[LW]                        = |m0_i;
        sum_o[LW+1]                      = |m1_i;
        sum_o[SC_BASE +: NUM_SC]         = sc_bits;
    end

endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NSRC = 72
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [7:0]      ctl_wdata,
    input  logic [NSRC-1:0] raw_i,
    input  logic [NSRC-1:0] masked_i,
    output logic [7:0]      ctl_o,
    output logic            irq_o,
    output logic            fiq_o
);

    typedef struct packed {
        logic       fen;
        logic [6:0] sel;
    } route_st_t;

    route_st_t s_d, s_q;
    logic [NSRC-1:0] irq_pool;
    logic            fiq_hit;

    always_comb begin
        s_d = s_q;
        if (ctl_we) begin
            s_d.fen = ctl_wdata[7];
            s_d.sel = ctl_wdata[6:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        irq_pool = masked_i;
        fiq_hit  = 1'b0;
        if (s_q.fen) begin
            for (int i = 0; i < NSRC; i++) begin
                if (i == int'(s_q.sel)) begin
                    irq_pool[i] = 1'b0;
                    fiq_hit     = raw_i[i];
                end
            end
        end
    end

    assign ctl_o = {s_q.fen, s_q.sel};
    assign irq_o = |irq_pool;
    assign fiq_o = fiq_hit;

    p_fiq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (ctl_o[7] && (int'(ctl_o[6:0]) < NSRC)));

    p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_o == $past(ctl_wdata)));

    p_irq_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[7] && (int'(ctl_o[6:0]) < NSRC) &&
         (masked_i == (NSRC'(1) << ctl_o[6:0]))) |-> !irq_o);

    p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[7] && (masked_i != '0)) |-> irq_o);

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int BW = BANK_W,
    parameter int LW = LOC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BW+LW-1:0]  src_i,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);

    localparam int NSRC   = 2 * BW + LW;
    localparam int NPBANK = 2;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic              wr, rd;
    logic [BW-1:0]     raw_b  [NPBANK];
    logic [BW-1:0]     en_b   [NPBANK];
    logic [BW-1:0]     mask_b [NPBANK];
    logic [LW-1:0]     raw_l, en_l, mask_l;
    logic [DATA_W-1:0] summary;
    logic [7:0]        fiq_ctl;
    logic [DATA_W-1:0] rd_val;

    assign wr = req_i && we_i;
    assign rd = req_i && !we_i;

    for (genvar gb = 0; gb < NPBANK; gb++) begin : g_pbank
        irq_bank #(.W(BW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (src_i[gb*BW +: BW]),
            .set_we   (wr && (addr_i == ADDR_W'(A_SET0) + ADDR_W'(gb))),
            .clr_we   (wr && (addr_i == ADDR_W'(A_CLR0) + ADDR_W'(gb))),
            .wdata_i  (wdata_i[BW-1:0]),
            .raw_o    (raw_b[gb]),
            .en_o     (en_b[gb]),
            .masked_o (mask_b[gb])
        );
    end

    irq_bank #(.W(LW)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i[NSRC-1 -: LW]),
        .set_we   (wr && (addr_i == A_SETL)),
        .clr_we   (wr && (addr_i == A_CLRL)),
        .wdata_i  (wdata_i[LW-1:0]),
        .raw_o    (raw_l),
        .en_o     (en_l),
        .masked_o (mask_l)
    );

    irq_summary #(.BW(BW), .LW(LW)) u_sum (
        .m0_i  (mask_b[0]),
        .m1_i  (mask_b[1]),
        .ml_i  (mask_l),
        .sum_o (summary)
    );

    irq_route #(.NSRC(NSRC)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (wr && (addr_i == A_FIQCTL)),
        .ctl_wdata (wdata_i[7:0]),
        .raw_i     ({raw_l, raw_b[1], raw_b[0]}),
        .masked_i  ({mask_l, mask_b[1], mask_b[0]}),
        .ctl_o     (fiq_ctl),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    always_comb begin
        rd_val = '0;
        case (addr_i)
            A_SUMMARY: rd_val = summary;
            A_MPEND0:  rd_val = DATA_W'(mask_b[0]);
            A_MPEND1:  rd_val = DATA_W'(mask_b[1]);
            A_FIQCTL:  rd_val = DATA_W'(fiq_ctl);
            A_SET0,
            A_CLR0:    rd_val = DATA_W'(en_b[0]);
            A_SET1,
            A_CLR1:    rd_val = DATA_W'(en_b[1]);
            A_SETL,
            A_CLRL:    rd_val = DATA_W'(en_l);
            A_RAW0:    rd_val = DATA_W'(raw_b[0]);
            A_RAW1:    rd_val = DATA_W'(raw_b[1]);
            A_RAWL:    rd_val = DATA_W'(raw_l);
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (rd) begin
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_o));

    p_sum_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_ctl[7] |-> (irq_o == (summary[LW+1:0] != '0)));

endmodule

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/1ps
module banked_irq_ctrl_test;

    localparam int NSRC = 72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] src = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    int unsigned sc_list [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    // reference model state
    logic [71:0] m_raw, m_en;
    logic        m_fen;
    logic [6:0]  m_sel;
    logic [31:0] m_rd;

    always #4 clk = ~clk;

    banked_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [71:0] mk;
        logic [31:0] v;
        mk = m_raw & m_en;
        v = 0;
        case (a)
            4'd0: begin
                for (int k = 0; k < 8; k++) v[k] = mk[64+k];
                v[8] = (mk[31:0] != 0);
                v[9] = (mk[63:32] != 0);
                for (int k = 0; k < 11; k++) v[10+k] = mk[sc_list[k]];
            end
            4'd1: v = mk[31:0];
            4'd2: v = mk[63:32];
            4'd3: v = {24'd0, m_fen, m_sel};
            4'd4, 4'd7: v = m_en[31:0];
            4'd5, 4'd8: v = m_en[63:32];
            4'd6, 4'd9: v = {24'd0, m_en[71:64]};
            4'd10: v = m_raw[31:0];
            4'd11: v = m_raw[63:32];
            4'd12: v = {24'd0, m_raw[71:64]};
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic logic m_irq();
        logic r;
        r = 0;
        for (int i = 0; i < NSRC; i++)
            if (m_raw[i] && m_en[i] && !(m_fen && i == int'(m_sel))) r = 1;
        return r;
    endfunction

    function automatic logic m_fiq();
        return m_fen && (int'(m_sel) < NSRC) && m_raw[m_sel];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_raw = 0; m_en = 0; m_fen = 0; m_sel = 0; m_rd = 0;
        end else begin
            if (req && !we) m_rd = m_read(addr);
            if (req && we) begin
                case (addr)
                    4'd3: begin m_fen = wdata[7]; m_sel = wdata[6:0]; end
                    4'd4: m_en[31:0]  = m_en[31:0]  | wdata;
                    4'd5: m_en[63:32] = m_en[63:32] | wdata;
                    4'd6: m_en[71:64] = m_en[71:64] | wdata[7:0];
                    4'd7: m_en[31:0]  = m_en[31:0]  & ~wdata;
                    4'd8: m_en[63:32] = m_en[63:32] & ~wdata;
                    4'd9: m_en[71:64] = m_en[71:64] & ~wdata[7:0];
                    default: ;
                endcase
            end
            m_raw = src;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FIAL_MARK"); // placeholder never printed
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            chk(cur_req, "rdata", rdata, m_rd);
            chk("R9", "irq", {31'd0, irq}, {31'd0, m_irq()});
            chk("R8", "fiq", {31'd0, fiq}, {31'd0, m_fiq()});
        end
    end

    task automatic op(input logic r, input logic w, input logic [3:0] a,
                      input logic [31:0] d);
        @(negedge clk);
        req = r; we = w; addr = a; wdata = d;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        op(1, 1, a, d);
    endtask

    task automatic rd(input logic [3:0] a);
        op(1, 0, a, 0);
        op(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1", "rdata after reset", rdata, 0);
        chk("R1", "irq after reset", {31'd0, irq}, 0);
        chk("R1", "fiq after reset", {31'd0, fiq}, 0);
        cmp_on = 1;
        cur_req = "R1";
        rd(4'd4); rd(4'd3);

        cur_req = "R2";
        src = 72'h0_00000000_00000681;
        wr(4'd4, 32'h0000_0601);
        rd(4'd1);
        wr(4'd4, 32'h0);
        rd(4'd4);
        wr(4'd4, 32'h0000_0080);
        rd(4'd1);

        cur_req = "R3";
        wr(4'd7, 32'h0000_0001);
        rd(4'd7);
        wr(4'd7, 32'h0);
        rd(4'd4);
        rd(4'd1);

        cur_req = "R4";
        src = 72'hC3_8000_0001_DEAD_BEEF;
        wr(4'd5, 32'h8000_0000);
        rd(4'd10); rd(4'd11); rd(4'd12); rd(4'd2); rd(4'd1);

        cur_req = "R5";
        wr(4'd6, 32'h0000_00A5);
        rd(4'd0);
        src[71:64] = 8'h5A;
        rd(4'd0);

        cur_req = "R6";
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFF);
        src = '0;
        src[40] = 1;
        rd(4'd0);
        wr(4'd5, 32'h0000_0100);
        rd(4'd0);
        src[3] = 1;
        wr(4'd4, 32'h0000_0008);
        rd(4'd0);

        cur_req = "R7";
        src = '0;
        foreach (sc_list[k]) src[sc_list[k]] = 1;
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd0);
        wr(4'd8, 32'h0020_0000);
        rd(4'd0);
        wr(4'd7, 32'h0000_0080);
        rd(4'd0);

        cur_req = "R8";
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        src = '0;
        src[70] = 1;
        wr(4'd3, 32'h0000_00C6);
        rd(4'd3);
        wr(4'd3, 32'h0000_00E4);
        rd(4'd3);
        wr(4'd3, 32'h0000_0000);
        rd(4'd3);

        cur_req = "R9";
        wr(4'd6, 32'h0000_0040);
        wr(4'd3, 32'h0000_00C6);
        op(0, 0, 0, 0); op(0, 0, 0, 0);
        src[65] = 1;
        wr(4'd6, 32'h0000_0002);
        op(0, 0, 0, 0);
        wr(4'd3, 32'h0);
        op(0, 0, 0, 0);

        cur_req = "R10";
        src[12] = 1;
        wr(4'd4, 32'h0000_1000);
        rd(4'd13); rd(4'd15);
        op(1, 0, 4'd1, 0);
        src[12] = 0;
        op(0, 0, 0, 0);
        op(0, 0, 0, 0);

        cur_req = "mixed";
        for (int n = 0; n < 2000; n++) begin
            logic [3:0] a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 15));
            d = $urandom;
            if (a == 4'd3) d = {24'd0, 1'($urandom), 7'($urandom_range(0, 80))};
            if (($urandom % 3) == 0) src = {8'($urandom), 32'($urandom), 32'($urandom)};
            op(($urandom % 4) != 0, ($urandom % 2) == 0, a, d);
        end
        op(0, 0, 0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule